// File: doc/BRIEF.md
# Load-Destination Register Rename Stage

This block sits at the front of an out-of-order core and converts architected register numbers into physical register numbers for a pool of 40 physical registers that backs 32 architected ones. Each cycle up to two instructions arrive together. Each carries three source specifiers and one destination specifier, and all eight are translated through a 32-entry map table in the same cycle. The translated specifiers are returned combinationally.

Only instructions flagged as loads receive a fresh destination register. The fresh register comes from the head of a circular free queue. The register that the destination used to map to is not freed at once. It is appended to a second circular queue of registers that wait for their last reader to finish. A one-bit release request moves the oldest waiting register back to the tail of the free queue. Detecting the last use belongs to the surrounding pipeline.

When the free queue cannot supply every load presented in a cycle, the stage raises stall and commits nothing that cycle. Within a pair, the second instruction sees the first instruction's new mapping, so the pair behaves as if it had been renamed one instruction at a time.

Top module: `regrename_stage`

## Requirements
- R1: After reset, every architected register n (0..31) translates to physical register n, for both sources and destinations.
- R2: After reset, the free queue holds physical registers 32 to 39 in that order and the waiting queue is empty, so the first load accepted after reset receives register 32 and the next receives 33.
- R3: An instruction whose valid bit is 0, or whose load flag is 0, changes neither the map table nor either queue. Its destination output is the current translation of its destination specifier.
- R4: An accepted load receives the register at the head of the free queue on its destination output. From the next cycle on, every source naming that architected register translates to the new register. The load's own sources still see the mapping that held before it.
- R5: The mapping a load replaces is appended to the waiting queue, and waiting registers return to the free queue in the order they were appended.
- R6: Stall is 1 exactly when the number of valid loads presented is greater than the number of registers in the free queue. A stalled cycle leaves the map table unchanged. A cycle with no loads never stalls.
- R7: In lane 1, a source or non-load destination that names the destination of an accepted load in lane 0 translates to lane 0's new register. When both lanes hold loads, lane 0 takes the free-queue head and lane 1 takes the next entry.
- R8: Release moves one waiting register per cycle to the free-queue tail. It has no effect while the waiting queue is empty. The free and waiting queues together always hold 8 registers.
- R9: When both lanes load the same architected destination, lane 1's replaced mapping is lane 0's new register, and after the cycle the map holds lane 1's register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 2 | Per-lane instruction present |
| in_is_load | input | 2 | Per-lane load flag; only loads allocate |
| in_dst | input | 10 | Destination specifiers, lane j at bits [5j+4:5j] |
| in_src | input | 30 | Source specifiers, lane j source k at bits [(3j+k)*5 +: 5] |
| rel_req | input | 1 | Return the oldest waiting register to the free queue |
| out_dst | output | 12 | Translated destination, lane j at bits [6j+5:6j] |
| out_src | output | 36 | Translated sources, lane j source k at bits [(3j+k)*6 +: 6] |
| stall | output | 1 | Not enough free registers for this cycle's loads |

## Verification
The assertions take for granted that the surrounding pipeline holds its instruction pair steady while stall is high, and that it asserts release only for a register whose last reader has left. The queue-count properties do not depend on that second assumption, because a release with nothing waiting is defined to do nothing. The directed stimulus keeps to these rules. It presents loads only between whole rename cycles, issues releases in cycles with no loads, so that each count change has a single cause, and drains the waiting queue completely before it sends extra releases. The free queue is wrapped more than once, so the returned order shows up in the destination numbers observed at the ports.

// File: rtl/rn_pkg.sv
package rn_pkg;
  // Default geometry of the rename stage.
  localparam int RN_ARCH_N = 32;
  localparam int RN_PHYS_N = 40;
  localparam int RN_LANES  = 2;
  localparam int RN_SRC_N  = 3;
endpackage

// File: rtl/rn_queue.sv
// Circular queue with several push and pop slots per cycle.
// DEPTH must be a power of two so the pointers wrap by truncation.
module rn_queue #(
  parameter int DEPTH = 8,
  parameter int W = 6,
  parameter int NPUSH = 1,
  parameter int NPOP = 1,
  parameter bit INIT_FULL = 1'b0,
  parameter int INIT_BASE = 0,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPUSH-1:0] push_en,
  input  logic [NPUSH*W-1:0] push_data,
  input  logic [NPOP-1:0]  pop_en,
  output logic [NPOP*W-1:0] head_data,
  output logic [CW-1:0]    count
);
  logic [W-1:0]    mem     [DEPTH];
  logic [W-1:0]    mem_nxt [DEPTH];
  logic [PTRW-1:0] head, tail, head_nxt, tail_nxt;
  logic [CW-1:0]   cnt_nxt;
  logic            upd;

  always_comb begin
    int slot;
    int pops;
    mem_nxt = mem;
    slot = 0;
    pops = 0;
    for (int k = 0; k < NPUSH; k++) begin
      if (push_en[k]) begin
        mem_nxt[PTRW'(tail + PTRW'(slot))] = push_data[k*W +: W];
        slot++;
      end
    end
    for (int k = 0; k < NPOP; k++) begin
      if (pop_en[k]) pops++;
    end
    tail_nxt = tail + PTRW'(slot);
    head_nxt = head + PTRW'(pops);
    cnt_nxt  = CW'(int'(count) + slot - pops);
    upd      = (|push_en) || (|pop_en);
    for (int k = 0; k < NPOP; k++) begin
      head_data[k*W +: W] = mem[PTRW'(head + PTRW'(k))];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= INIT_FULL ? W'(INIT_BASE + i) : '0;
      end
      head  <= '0;
      tail  <= '0;
      count <= INIT_FULL ? CW'(DEPTH) : '0;
    end else if (upd) begin
      mem   <= mem_nxt;
      head  <= head_nxt;
      tail  <= tail_nxt;
      count <= cnt_nxt;
    end
  end
endmodule

// File: rtl/rn_maptab.sv
// Architected-to-physical map: many combinational reads, ordered writes.
module rn_maptab #(
  parameter int ENTRIES = 32,
  parameter int PW = 6,
  parameter int NWR = 2,
  parameter int NRD = 8,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NWR-1:0]   wr_en,
  input  logic [NWR*AW-1:0] wr_addr,
  input  logic [NWR*PW-1:0] wr_data,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD*PW-1:0] rd_data
);
  logic [PW-1:0] tab     [ENTRIES];
  logic [PW-1:0] tab_nxt [ENTRIES];
  logic          upd;

  always_comb begin
    tab_nxt = tab;
    // Higher-numbered port is younger and wins on equal addresses.
    for (int w = 0; w < NWR; w++) begin
      if (wr_en[w]) tab_nxt[wr_addr[w*AW +: AW]] = wr_data[w*PW +: PW];
    end
    upd = |wr_en;
    for (int r = 0; r < NRD; r++) begin
      rd_data[r*PW +: PW] = tab[rd_addr[r*AW +: AW]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tab[i] <= PW'(i);
    end else if (upd) begin
      tab <= tab_nxt;
    end
  end
endmodule

// File: rtl/regrename_stage.sv
module regrename_stage #(
  parameter int ARCH_N = rn_pkg::RN_ARCH_N,
  parameter int PHYS_N = rn_pkg::RN_PHYS_N,
  parameter int LANES  = rn_pkg::RN_LANES,
  parameter int SRC_N  = rn_pkg::RN_SRC_N,
  localparam int AW = $clog2(ARCH_N),
  localparam int PW = $clog2(PHYS_N),
  localparam int POOL_N = PHYS_N - ARCH_N,
  localparam int CW = $clog2(POOL_N + 1),
  localparam int NRD = LANES * (SRC_N + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         in_valid,
  input  logic [LANES-1:0]         in_is_load,
  input  logic [LANES*AW-1:0]      in_dst,
  input  logic [LANES*SRC_N*AW-1:0] in_src,
  input  logic                     rel_req,
  output logic [LANES*PW-1:0]      out_dst,
  output logic [LANES*SRC_N*PW-1:0] out_src,
  output logic                     stall
);
  logic [CW-1:0]       free_cnt, pend_cnt;
  logic [LANES*PW-1:0] free_head;
  logic [PW-1:0]       pend_head;
  logic [NRD*AW-1:0]   rd_addr;
  logic [NRD*PW-1:0]   rd_data;
  logic [LANES-1:0]    is_ld, wr_en, free_pop;
  logic [LANES*PW-1:0] new_flat, old_flat;
  logic [PW-1:0]       new_reg [LANES];
  logic [PW-1:0]       dst_tr  [LANES];
  logic                rel_go;

  // Sources occupy the low read ports, destinations the high ones.
  assign rd_addr = {in_dst, in_src};
  assign is_ld   = in_valid & in_is_load;
  assign rel_go  = rel_req && (pend_cnt != '0);

  always_comb begin
    int ld_num;
    int rank;
    logic [PW-1:0] tr;
    ld_num = 0;
    for (int j = 0; j < LANES; j++) if (is_ld[j]) ld_num++;
    stall = ld_num > int'(free_cnt);

    // Allocation order follows lane order.
    rank = 0;
    for (int j = 0; j < LANES; j++) begin
      new_reg[j] = '0;
      if (is_ld[j]) begin
        new_reg[j] = free_head[rank*PW +: PW];
        rank++;
      end
    end

    // Translation with forwarding from older lanes' loads.
    for (int j = 0; j < LANES; j++) begin
      for (int k = 0; k < SRC_N; k++) begin
        tr = rd_data[(j*SRC_N+k)*PW +: PW];
        for (int i = 0; i < j; i++) begin
          if (is_ld[i] && in_dst[i*AW +: AW] == in_src[(j*SRC_N+k)*AW +: AW])
            tr = new_reg[i];
        end
        out_src[(j*SRC_N+k)*PW +: PW] = tr;
      end
      tr = rd_data[(LANES*SRC_N+j)*PW +: PW];
      for (int i = 0; i < j; i++) begin
        if (is_ld[i] && in_dst[i*AW +: AW] == in_dst[j*AW +: AW]) tr = new_reg[i];
      end
      dst_tr[j] = tr;
      out_dst[j*PW +: PW]  = is_ld[j] ? new_reg[j] : tr;
      new_flat[j*PW +: PW] = new_reg[j];
      old_flat[j*PW +: PW] = tr;
      wr_en[j]    = is_ld[j] && !stall;
      free_pop[j] = !stall && (j < ld_num);
    end
  end

  rn_maptab #(.ENTRIES(ARCH_N), .PW(PW), .NWR(LANES), .NRD(NRD)) u_map (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(in_dst), .wr_data(new_flat),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  rn_queue #(.DEPTH(POOL_N), .W(PW), .NPUSH(1), .NPOP(LANES),
             .INIT_FULL(1'b1), .INIT_BASE(ARCH_N)) u_free (
    .clk(clk), .rst_n(rst_n),
    .push_en(rel_go), .push_data(pend_head),
    .pop_en(free_pop), .head_data(free_head), .count(free_cnt)
  );

  rn_queue #(.DEPTH(POOL_N), .W(PW), .NPUSH(LANES), .NPOP(1),
             .INIT_FULL(1'b0), .INIT_BASE(0)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .push_en(wr_en), .push_data(old_flat),
    .pop_en(rel_go), .head_data(pend_head), .count(pend_cnt)
  );
endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
  parameter int LANES = 2,
  parameter int POOL_N = 8,
  parameter int CW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] in_valid,
  input logic [LANES-1:0] in_is_load,
  input logic             rel_req,
  input logic             stall,
  input logic [CW-1:0]    free_cnt,
  input logic [CW-1:0]    pend_cnt
);
  int ld;
  assign ld = $countones(in_valid & in_is_load);

  AST_POOL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_cnt) + int'(pend_cnt) == POOL_N); // R8

  AST_STALL_KEEPS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !rel_req |=> free_cnt == $past(free_cnt)); // R6

  AST_NO_LOAD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ld == 0 |-> !stall); // R6

  AST_LOAD_TAKES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !stall && !rel_req |=> int'(free_cnt) == int'($past(free_cnt)) - $past(ld)); // R4

  AST_LOAD_FILLS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !stall && !rel_req |=> int'(pend_cnt) == int'($past(pend_cnt)) + $past(ld)); // R5

  AST_REL_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    rel_req && pend_cnt == '0 && ld == 0 |=> pend_cnt == '0); // R8
endmodule

bind regrename_stage rn_checker #(.LANES(LANES), .POOL_N(POOL_N), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_load(in_is_load),
  .rel_req(rel_req), .stall(stall), .free_cnt(free_cnt), .pend_cnt(pend_cnt)
);

// File: tb/sim_regrename_stage.sv
`timescale 1ns/1ps
module sim_regrename_stage;
  logic        clk, rst_n;
  logic [1:0]  in_valid, in_is_load;
  logic [9:0]  in_dst;
  logic [29:0] in_src;
  logic        rel_req;
  logic [11:0] out_dst;
  logic [35:0] out_src;
  logic        stall;
  int checks = 0, errors = 0;
  bit done = 0;

  regrename_stage u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_is_load(in_is_load), .in_dst(in_dst), .in_src(in_src),
    .rel_req(rel_req), .out_dst(out_dst), .out_src(out_src), .stall(stall));

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int osrc(int l, int k);
    return int'(out_src[(l*3+k)*6 +: 6]);
  endfunction
  function automatic int odst(int l);
    return int'(out_dst[l*6 +: 6]);
  endfunction

  task automatic put(int l, bit v, bit ld, int d, int a, int b, int c);
    in_valid[l] = v;
    in_is_load[l] = ld;
    in_dst[l*5 +: 5] = 5'(d);
    in_src[(l*3+0)*5 +: 5] = 5'(a);
    in_src[(l*3+1)*5 +: 5] = 5'(b);
    in_src[(l*3+2)*5 +: 5] = 5'(c);
  endtask

  task automatic clr();
    in_valid = '0; in_is_load = '0; in_dst = '0; in_src = '0; rel_req = 0;
  endtask

  // Commit at the next rising edge, return at the falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    clr();
  endtask

  task automatic releases(int n);
    for (int i = 0; i < n; i++) begin
      rel_req = 1;
      step();
    end
  endtask

  task automatic t_reset();
    put(0, 1, 0, 7, 0, 5, 31);
    put(1, 1, 0, 31, 1, 30, 16);
    #1;
    chk("R1 src0", osrc(0, 0), 0);
    chk("R1 src5", osrc(0, 1), 5);
    chk("R1 src31", osrc(0, 2), 31);
    chk("R1 dst7", odst(0), 7);
    chk("R1 lane1 src30", osrc(1, 1), 30);
    chk("R1 no stall", int'(stall), 0);
    step();
  endtask

  task automatic t_plain();
    put(0, 1, 0, 3, 1, 2, 3);
    put(1, 0, 1, 4, 4, 30, 0);   // invalid lane flagged as load
    #1;
    chk("R3 dst3", odst(0), 3);
    step();
    put(0, 1, 0, 9, 3, 4, 9);
    #1;
    chk("R3 map3 kept", osrc(0, 0), 3);
    chk("R3 map4 kept", osrc(0, 1), 4);
    step();
  endtask

  task automatic t_load();
    put(0, 1, 1, 10, 10, 1, 2);
    #1;
    chk("R2 first alloc", odst(0), 32);
    chk("R4 own src old", osrc(0, 0), 10);
    step();
    put(0, 1, 0, 0, 10, 10, 0);
    #1;
    chk("R4 later src new", osrc(0, 0), 32);
    step();
  endtask

  task automatic t_bypass();
    put(0, 1, 1, 11, 11, 0, 0);
    put(1, 1, 0, 11, 11, 10, 12);
    #1;
    chk("R2 second alloc", odst(0), 33);
    chk("R7 lane0 sees old", osrc(0, 0), 11);
    chk("R7 lane1 fwd", osrc(1, 0), 33);
    chk("R7 lane1 other", osrc(1, 1), 32);
    chk("R7 lane1 plain", osrc(1, 2), 12);
    chk("R7 lane1 dst fwd", odst(1), 33);
    step();
  endtask

  task automatic t_dual();
    put(0, 1, 1, 12, 0, 0, 0);
    put(1, 1, 1, 12, 12, 0, 0);
    #1;
    chk("R7 dual lane0", odst(0), 34);
    chk("R7 dual lane1", odst(1), 35);
    chk("R9 lane1 src fwd", osrc(1, 0), 34);
    step();
    put(0, 1, 0, 0, 12, 0, 0);
    #1;
    chk("R9 final map", osrc(0, 0), 35);
    step();
  endtask

  task automatic t_stall();
    put(0, 1, 1, 13, 0, 0, 0);
    put(1, 1, 1, 14, 0, 0, 0);
    #1;
    chk("R4 fill a", odst(1), 37);
    step();
    put(0, 1, 1, 15, 0, 0, 0);
    put(1, 1, 1, 16, 0, 0, 0);
    #1;
    chk("R4 fill b", odst(1), 39);
    step();
    put(0, 1, 1, 20, 20, 0, 0);
    #1;
    chk("R6 stall empty", int'(stall), 1);
    step();
    put(0, 1, 0, 20, 20, 0, 0);
    #1;
    chk("R6 map unchanged", osrc(0, 0), 20);
    chk("R6 non-load no stall", int'(stall), 0);
    step();
  endtask

  task automatic t_release();
    releases(1);
    put(0, 1, 1, 20, 0, 0, 0);
    put(1, 1, 1, 21, 0, 0, 0);
    #1;
    chk("R6 two loads one free", int'(stall), 1);
    step();
    put(0, 1, 1, 20, 20, 0, 0);
    #1;
    chk("R6 one load fits", int'(stall), 0);
    chk("R5 oldest returned", odst(0), 10);
    chk("R4 own src old", osrc(0, 0), 20);
    step();
    releases(2);
    put(0, 1, 1, 21, 0, 0, 0);
    put(1, 1, 1, 22, 0, 0, 0);
    #1;
    chk("R5 order a", odst(0), 11);
    chk("R5 order b", odst(1), 12);
    step();
  endtask

  task automatic t_drain();
    int exp_a[4] = '{34, 14, 16, 21};
    int exp_b[4] = '{13, 15, 20, 22};
    releases(8);
    releases(2);   // waiting queue empty: must be ignored
    for (int i = 0; i < 4; i++) begin
      put(0, 1, 1, 1 + 2*i, 0, 0, 0);
      put(1, 1, 1, 2 + 2*i, 0, 0, 0);
      #1;
      chk("R8 drained no stall", int'(stall), 0);
      chk("R8 drained order a", odst(0), exp_a[i]);
      chk("R8 drained order b", odst(1), exp_b[i]);
      step();
    end
    put(0, 1, 1, 9, 0, 0, 0);
    #1;
    chk("R8 extra release ignored", int'(stall), 1);
    step();
  endtask

  initial begin
    clr();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_load();
    t_bypass();
    t_dual();
    t_stall();
    t_release();
    t_drain();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule